// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block watches the instruction fetch stream of a main processor and checks that the program runs its blocks in a legal order. Each program block is free of branches. The fetched words arrive tagged by kind:

- a header word holding the block's signature;
- the body instructions;
- two signature words naming the headers of the two possible successor blocks;
- the closing branch instruction.

The watchdog folds the body words together with XOR and compares the result against the header. It also checks that each new header matches the successor signature chosen by the branch outcome.

On a violation the watchdog emits a one-cycle error class and a micro-rollback request with a depth, and its own checking state rolls back to match. For a header mismatch, the depth grows with a saturating count of repeated header errors that is compared against two thresholds. For a body-signature mismatch, the depth is the size of the block. A bus ECC checker can request its own rollback at the same time. The ECC request always wins, and the word fetched in that cycle is thrown away.

Top module: `cf_watchdog`

## Requirements
- R1: After reset all outputs are 0 and the checker waits for a first header. Non-header words are ignored until that header arrives, and the first header is accepted without comparison.
- R2: Word kinds on fetch_kind are 0 body instruction, 1 header, 2 signature, 3 branch. When the branch word is accepted, the next expected header becomes the second signature word if branch_taken is 1 and the first signature word otherwise.
- R3: A header that differs from the expected header produces err_class 1 with a rollback request.
- R4: For a header error with repeat count t taken before the error: if t < T1 the depth is 1 and the checker waits for the header again. If T1 <= t < T2 the depth is 2 and the checker waits for the branch word again. If t >= T2 the depth is 3 and the checker waits for both signature words again.
- R5: The first signature word after the body triggers the body check: the XOR of all body words, cleared when the header is accepted, must equal the header. On a mismatch the output is err_class 2 with depth equal to the number of words in the block including the header, saturated at 7, and the checker waits for the header again.
- R6: The repeat count rises by one on every header error, saturates, and is cleared when a body check passes.
- R7: A word whose kind does not fit the current step produces err_class 3 with depth 1. The checking step and the repeat count are left unchanged.
- R8: While ecc_req is 1, the block outputs rb_valid=1, rb_from_ecc=1, rb_depth=1 and err_class=0 one cycle later. The fetched word of that cycle is discarded and the repeat count is not touched.
- R9: A cycle with fetch_valid at 0 and ecc_req at 0 changes nothing.
- R10: Outputs are registered and appear one cycle after the input word. A watchdog error always carries rb_valid=1 and rb_from_ecc=0. With no request, rb_valid and rb_depth are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetched word is present |
| fetch_kind | input | 2 | Kind tag of the fetched word |
| fetch_word | input | DATA_W | Fetched instruction or signature word |
| branch_taken | input | 1 | Outcome of the branch word |
| ecc_req | input | 1 | Bus ECC checker asks for a rollback |
| err_class | output | 2 | 0 none, 1 header, 2 body signature, 3 order |
| rb_valid | output | 1 | Rollback request pulse |
| rb_depth | output | 3 | Requested rollback depth in instructions |
| rb_from_ecc | output | 1 | Request comes from the ECC source |

## Verification
A watchdog error and an ECC rollback request can fall in the same cycle. The bench provokes this by presenting a wrong header, and later a header that would pass, together with ecc_req. The correct outcome is a depth-1 ECC request with no error class. The next fetch of the same wrong header must then produce the depth that the unchanged repeat count implies, which shows that the colliding word neither advanced the checking step nor counted as an error.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int RB_W = 3;

    typedef enum logic [1:0] {
        WK_INSN   = 2'd0,
        WK_HDR    = 2'd1,
        WK_SIG    = 2'd2,
        WK_BRANCH = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        EC_NONE     = 2'd0,
        EC_HEADER   = 2'd1,
        EC_COMPUTED = 2'd2,
        EC_ORDER    = 2'd3
    } err_class_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_BEGIN,
        CS_BODY,
        CS_RESIG1,
        CS_SIG2,
        CS_BRANCH
    } chk_state_e;

    localparam logic [RB_W-1:0] DEPTH_HEADER = 3'd1;
    localparam logic [RB_W-1:0] DEPTH_BRANCH = 3'd2;
    localparam logic [RB_W-1:0] DEPTH_SIGS   = 3'd3;

    // rollback depth chosen from the repeat count and two thresholds
    function automatic logic [RB_W-1:0] repeat_depth(input int cnt, input int lo, input int hi);
        if (cnt >= hi)      return DEPTH_SIGS;
        else if (cnt >= lo) return DEPTH_BRANCH;
        else                return DEPTH_HEADER;
    endfunction

endpackage

// File: rtl/cfw_accum.sv
module cfw_accum
    import cfw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              add,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] acc,
    output logic [RB_W-1:0]   size
);
    localparam logic [RB_W-1:0] SIZE_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            size <= 3'd1;
        end else if (start) begin
            acc  <= '0;
            size <= 3'd1;
        end else if (add) begin
            acc  <= acc ^ word;
            if (size != SIZE_MAX) size <= size + 3'd1;
        end
    end

    // R5: block size never wraps to zero
    assert_size_nonzero_R5: assert property (@(posedge clk) disable iff (rst) size != '0);
    assert_size_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (add && !start && size == SIZE_MAX) |=> size == SIZE_MAX);

endmodule

// File: rtl/cfw_repeat.sv
module cfw_repeat
    import cfw_pkg::*;
#(
    parameter int T1    = 2,
    parameter int T2    = 4,
    parameter int CNT_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            clr,
    output logic [RB_W-1:0] depth
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    generate
        if (T1 < 1 || T2 <= T1 || T2 > int'(CNT_MAX)) begin : g_bad_thresholds
            $error("cfw_repeat: thresholds must satisfy 1 <= T1 < T2 <= counter maximum");
        end
    endgenerate

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)            cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    always_comb depth = repeat_depth(int'(cnt), T1, T2);

    // R6: counter saturates rather than wrapping
    assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
    assert_cnt_mono_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr) |=> cnt >= $past(cnt));

endmodule

// File: rtl/cfw_rb_out.sv
module cfw_rb_out
    import cfw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ecc_req,
    input  err_class_e      wd_err,
    input  logic [RB_W-1:0] wd_depth,
    output err_class_e      err_q,
    output logic            rb_valid,
    output logic [RB_W-1:0] rb_depth,
    output logic            rb_from_ecc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q       <= EC_NONE;
            rb_valid    <= 1'b0;
            rb_depth    <= '0;
            rb_from_ecc <= 1'b0;
        end else if (ecc_req) begin
            err_q       <= EC_NONE;
            rb_valid    <= 1'b1;
            rb_depth    <= DEPTH_HEADER;
            rb_from_ecc <= 1'b1;
        end else if (wd_err != EC_NONE) begin
            err_q       <= wd_err;
            rb_valid    <= 1'b1;
            rb_depth    <= wd_depth;
            rb_from_ecc <= 1'b0;
        end else begin
            err_q       <= EC_NONE;
            rb_valid    <= 1'b0;
            rb_depth    <= '0;
            rb_from_ecc <= 1'b0;
        end
    end

    // R8: the ECC request wins over any watchdog error in the same cycle
    assert_ecc_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ecc_req |=> (rb_valid && rb_from_ecc && rb_depth == DEPTH_HEADER && err_q == EC_NONE));

endmodule

// File: rtl/cf_watchdog.sv
module cf_watchdog
    import cfw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int T1     = 2,
    parameter int T2     = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [1:0]        fetch_kind,
    input  logic [DATA_W-1:0] fetch_word,
    input  logic              branch_taken,
    input  logic              ecc_req,
    output logic [1:0]        err_class,
    output logic              rb_valid,
    output logic [2:0]        rb_depth,
    output logic              rb_from_ecc
);
    chk_state_e        state, nxt;
    word_kind_e        kind;
    logic              take;
    logic [DATA_W-1:0] hdr_sig, sig1, sig2, exp_sig, acc;
    logic [RB_W-1:0]   blk_size, rep_depth, wd_depth;
    err_class_e        wd_err, err_q;
    logic              acc_start, acc_add, rep_inc, rep_clr;
    logic              ld_hdr, ld_s1, ld_s2, ld_exp;

    assign kind = word_kind_e'(fetch_kind);
    assign take = fetch_valid && !ecc_req;

    cfw_accum #(.DATA_W(DATA_W)) u_accum (
        .clk(clk), .rst(rst), .start(acc_start), .add(acc_add),
        .word(fetch_word), .acc(acc), .size(blk_size)
    );

    cfw_repeat #(.T1(T1), .T2(T2), .CNT_W(CNT_W)) u_repeat (
        .clk(clk), .rst(rst), .inc(rep_inc), .clr(rep_clr), .depth(rep_depth)
    );

    cfw_rb_out u_out (
        .clk(clk), .rst(rst), .ecc_req(ecc_req), .wd_err(wd_err), .wd_depth(wd_depth),
        .err_q(err_q), .rb_valid(rb_valid), .rb_depth(rb_depth), .rb_from_ecc(rb_from_ecc)
    );

    assign err_class = err_q;

    always_comb begin
        nxt       = state;
        wd_err    = EC_NONE;
        wd_depth  = '0;
        acc_start = 1'b0;
        acc_add   = 1'b0;
        rep_inc   = 1'b0;
        rep_clr   = 1'b0;
        ld_hdr    = 1'b0;
        ld_s1     = 1'b0;
        ld_s2     = 1'b0;
        ld_exp    = 1'b0;
        if (take) begin
            case (state)
                CS_IDLE: begin
                    if (kind == WK_HDR) begin
                        acc_start = 1'b1;
                        ld_hdr    = 1'b1;
                        nxt       = CS_BODY;
                    end
                end
                CS_BEGIN: begin
                    if (kind != WK_HDR) begin
                        wd_err   = EC_ORDER;
                        wd_depth = DEPTH_HEADER;
                    end else if (fetch_word == exp_sig) begin
                        acc_start = 1'b1;
                        ld_hdr    = 1'b1;
                        nxt       = CS_BODY;
                    end else begin
                        wd_err   = EC_HEADER;
                        wd_depth = rep_depth;
                        rep_inc  = 1'b1;
                        if (rep_depth == DEPTH_BRANCH)    nxt = CS_BRANCH;
                        else if (rep_depth == DEPTH_SIGS) nxt = CS_RESIG1;
                        else                              nxt = CS_BEGIN;
                    end
                end
                CS_BODY: begin
                    if (kind == WK_INSN) begin
                        acc_add = 1'b1;
                    end else if (kind == WK_SIG) begin
                        if (acc == hdr_sig) begin
                            ld_s1   = 1'b1;
                            rep_clr = 1'b1;
                            nxt     = CS_SIG2;
                        end else begin
                            wd_err   = EC_COMPUTED;
                            wd_depth = blk_size;
                            nxt      = CS_BEGIN;
                        end
                    end else begin
                        wd_err   = EC_ORDER;
                        wd_depth = DEPTH_HEADER;
                    end
                end
                CS_RESIG1: begin
                    if (kind == WK_SIG) begin
                        ld_s1 = 1'b1;
                        nxt   = CS_SIG2;
                    end else begin
                        wd_err   = EC_ORDER;
                        wd_depth = DEPTH_HEADER;
                    end
                end
                CS_SIG2: begin
                    if (kind == WK_SIG) begin
                        ld_s2 = 1'b1;
                        nxt   = CS_BRANCH;
                    end else begin
                        wd_err   = EC_ORDER;
                        wd_depth = DEPTH_HEADER;
                    end
                end
                CS_BRANCH: begin
                    if (kind == WK_BRANCH) begin
                        ld_exp = 1'b1;
                        nxt    = CS_BEGIN;
                    end else begin
                        wd_err   = EC_ORDER;
                        wd_depth = DEPTH_HEADER;
                    end
                end
                default: nxt = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CS_IDLE;
            hdr_sig <= '0;
            sig1    <= '0;
            sig2    <= '0;
            exp_sig <= '0;
        end else begin
            state <= nxt;
            if (ld_hdr) hdr_sig <= fetch_word;
            if (ld_s1)  sig1    <= fetch_word;
            if (ld_s2)  sig2    <= fetch_word;
            if (ld_exp) exp_sig <= branch_taken ? sig2 : sig1;
        end
    end

    // R4: a header error never asks for more than three instructions
    assert_hdr_depth_R4: assert property (@(posedge clk) disable iff (rst)
        (err_class == EC_HEADER) |-> (rb_depth >= 3'd1 && rb_depth <= 3'd3));
    // R10: every watchdog error carries a watchdog rollback request
    assert_err_has_rb_R10: assert property (@(posedge clk) disable iff (rst)
        (err_class != EC_NONE) |-> (rb_valid && !rb_from_ecc));
    // R9: an idle cycle yields no request one cycle later
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!fetch_valid && !ecc_req) |=> !rb_valid);
    // R1: nothing is flagged while waiting for the very first header
    assert_first_hdr_R1: assert property (@(posedge clk) disable iff (rst)
        (state == CS_IDLE && !ecc_req) |=> !rb_valid);

endmodule

// File: tb/tb_cf_watchdog.sv
`timescale 1ns/1ps
module tb_cf_watchdog;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid, branch_taken, ecc_req;
    logic [1:0]  fetch_kind;
    logic [15:0] fetch_word;
    logic [1:0]  err_class;
    logic        rb_valid, rb_from_ecc;
    logic [2:0]  rb_depth;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cf_watchdog dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_kind(fetch_kind),
        .fetch_word(fetch_word), .branch_taken(branch_taken), .ecc_req(ecc_req),
        .err_class(err_class), .rb_valid(rb_valid), .rb_depth(rb_depth),
        .rb_from_ecc(rb_from_ecc)
    );

    typedef struct packed {
        logic        vld;
        logic [1:0]  kind;
        logic [15:0] word;
        logic        tk;
        logic        ecc;
        logic [1:0]  err;
        logic        rb;
        logic [2:0]  dep;
        logic        src;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 45;
    // kinds: 0 insn, 1 header, 2 signature, 3 branch ; T1=2, T2=4
    localparam vec_t VEC [NV] = '{
        '{1, 0, 16'h1234, 0, 0, 0, 0, 0, 0, 1},  // 0  R1 ignored before first header
        '{1, 1, 16'hA5A5, 0, 0, 0, 0, 0, 0, 1},  // 1  R1 first header accepted
        '{1, 0, 16'h00F0, 0, 0, 0, 0, 0, 0, 5},  // 2
        '{1, 0, 16'hA555, 0, 0, 0, 0, 0, 0, 5},  // 3
        '{1, 2, 16'h1111, 0, 0, 0, 0, 0, 0, 5},  // 4  R5 body XOR matches
        '{1, 2, 16'h2222, 0, 0, 0, 0, 0, 0, 2},  // 5
        '{1, 3, 16'h0000, 1, 0, 0, 0, 0, 0, 2},  // 6  R2 taken -> expect 2222
        '{1, 1, 16'h3333, 0, 0, 1, 1, 1, 0, 3},  // 7  R3 t=0
        '{1, 1, 16'h3333, 0, 0, 1, 1, 1, 0, 4},  // 8  R4 t=1
        '{1, 1, 16'h3333, 0, 0, 1, 1, 2, 0, 4},  // 9  R4 t=2 -> branch again
        '{1, 3, 16'h0000, 0, 0, 0, 0, 0, 0, 4},  // 10 R4 branch accepted, expect 1111
        '{1, 1, 16'h2222, 0, 0, 1, 1, 2, 0, 2},  // 11 R2 not-taken path, t=3
        '{1, 3, 16'h0000, 1, 0, 0, 0, 0, 0, 4},  // 12
        '{1, 1, 16'h0000, 0, 0, 1, 1, 3, 0, 4},  // 13 R4 t=4 -> signatures again
        '{1, 2, 16'h0BAD, 0, 0, 0, 0, 0, 0, 4},  // 14 R4 re-read first sig
        '{1, 2, 16'h0C0D, 0, 0, 0, 0, 0, 0, 4},  // 15
        '{1, 3, 16'h0000, 0, 0, 0, 0, 0, 0, 2},  // 16
        '{1, 1, 16'h0BAD, 0, 0, 0, 0, 0, 0, 2},  // 17 R2 new expected header
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 18
        '{1, 0, 16'h0002, 0, 0, 0, 0, 0, 0, 5},  // 19
        '{1, 2, 16'h4444, 0, 0, 2, 1, 3, 0, 5},  // 20 R5 mismatch, size 3
        '{1, 1, 16'h0BAD, 0, 0, 0, 0, 0, 0, 5},  // 21 R5 header re-read
        '{1, 0, 16'h0BAD, 0, 0, 0, 0, 0, 0, 5},  // 22
        '{1, 2, 16'h5555, 0, 0, 0, 0, 0, 0, 6},  // 23 R6 good body clears t
        '{1, 2, 16'h6666, 0, 0, 0, 0, 0, 0, 6},  // 24
        '{1, 3, 16'h0000, 0, 0, 0, 0, 0, 0, 6},  // 25
        '{1, 1, 16'h7777, 0, 0, 1, 1, 1, 0, 6},  // 26 R6 t back to 0
        '{1, 3, 16'h0000, 0, 0, 3, 1, 1, 0, 7},  // 27 R7 branch where header due
        '{1, 1, 16'h5555, 0, 1, 0, 1, 1, 1, 8},  // 28 R8 word discarded
        '{1, 1, 16'h5555, 0, 0, 0, 0, 0, 0, 8},  // 29 R8 same header now accepted
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 30
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 31
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 32
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 33
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 34
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 35
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 36
        '{1, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 5},  // 37
        '{1, 2, 16'h0001, 0, 0, 2, 1, 7, 0, 5},  // 38 R5 size 9 capped at 7
        '{1, 1, 16'h9999, 0, 1, 0, 1, 1, 1, 8},  // 39 R8 collision with bad header
        '{1, 1, 16'h9999, 0, 0, 1, 1, 1, 0, 8},  // 40 R8 t unchanged (1)
        '{1, 1, 16'h9999, 0, 0, 1, 1, 2, 0, 6},  // 41 R6 t=2
        '{0, 1, 16'h9999, 0, 0, 0, 0, 0, 0, 9},  // 42 R9 not valid
        '{1, 3, 16'h0000, 0, 0, 0, 0, 0, 0, 9},  // 43 R9 still waiting for branch
        '{1, 1, 16'h5555, 0, 0, 0, 0, 0, 0, 10}  // 44 R10 quiet after accept
    };

    task automatic drive(input logic v, input logic [1:0] k, input logic [15:0] w,
                         input logic t, input logic e);
        @(negedge clk);
        fetch_valid  = v;
        fetch_kind   = k;
        fetch_word   = w;
        branch_taken = t;
        ecc_req      = e;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [1:0] e, input logic r,
                         input logic [2:0] d, input logic s);
        checks++;
        if (err_class !== e || rb_valid !== r || rb_depth !== d || rb_from_ecc !== s) begin
            failures++;
            $display("FAIL %s got err=%0d rb=%0d depth=%0d ecc=%0d expected err=%0d rb=%0d depth=%0d ecc=%0d",
                     tag, err_class, rb_valid, rb_depth, rb_from_ecc, e, r, d, s);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; fetch_valid = 0; fetch_kind = 0; fetch_word = 0;
        branch_taken = 0; ecc_req = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].vld, VEC[i].kind, VEC[i].word, VEC[i].tk, VEC[i].ecc);
            check($sformatf("vec %0d R%0d", i, VEC[i].req),
                  VEC[i].err, VEC[i].rb, VEC[i].dep, VEC[i].src);
        end

        drive(0, 0, 16'h0, 0, 0);
        check("R10 pulse drops", 0, 0, 0, 0);

        // R1: mid-run reset returns to waiting for a first header
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset mid-run", 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        drive(1, 1, 16'h1357, 0, 0);
        check("R1 any first header", 0, 0, 0, 0);
        drive(1, 2, 16'h0000, 0, 0);
        check("R5 empty body vs header, depth 1", 2, 1, 1, 0);
        drive(0, 0, 16'h0, 0, 1);
        check("R8 ECC alone", 0, 1, 1, 1);
        drive(1, 0, 16'h0001, 0, 0);
        check("R7 insn where header due", 3, 1, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule